// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves one on-chip PLL from whatever it is doing to a new divider set, without ever letting consumers see the clock while it is out of lock. A single-cycle start pulse carries the wanted input divider NR, feedback multiplier NF and output divider NO. The sequencer first bypasses the PLL to the 24 MHz reference and puts it into reset. It then loads the dividers and the loop bandwidth field and holds reset for a fixed settling time. After releasing reset it checks the lock indication once per microsecond, and it hands the output back to the PLL only after lock is seen.

The output rate of the PLL follows Fout = (24 MHz / NR) * NF / NO. The block always shows the current output frequency in Hz, derived from the mode field and the stored divider fields, so a system can read the rate without knowing the sequencing history. If lock never comes, a timeout flags an error and leaves the PLL bypassed. Microsecond timing is derived from the system clock frequency, which is given as a parameter in MHz.

Top module: `pllseq_top`

## Requirements
- R1: After reset the mode field is deep-slow (code 2), PLL reset is low, all divider fields and the bandwidth field are zero, busy and error are low, and the rate output reads 32768.
- R2: A start pulse seen while idle sets the mode field to slow (code 0) and drives PLL reset high at the same clock edge. No divider field changes at that edge.
- R3: One clock after the start is taken, the divider fields hold NR-1, NF-1 and NO-1 and the bandwidth field holds (NF>>1)-1.
- R4: PLL reset stays high for exactly RESET_US*CLK_MHZ clocks after the dividers are loaded, then falls while the mode is still slow.
- R5: After reset is released, lock is sampled every CLK_MHZ clocks. At the first sample that finds lock high, the mode field becomes normal (code 1) at that edge.
- R6: Busy rises with the accepted start and falls at the edge where the mode becomes normal or where a timeout ends the attempt.
- R7: A start pulse that arrives while busy is ignored, and the sequence in flight completes with the dividers of the first request.
- R8: After LOCK_TIMEOUT_US failed lock samples, error goes high, busy falls and the mode stays slow. The next accepted start clears error.
- R9: The rate output shows 24000000 in slow mode and floor(24*NF/(NR*NO))*1000000 in normal mode, with each divider taken as its field plus one. Deep-slow and the unused mode code 3 read as 32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_MHZ |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle request to reprogram the PLL |
| reqNr | input | NR_W | Requested input divider NR (1 or more) |
| reqNf | input | NF_W | Requested feedback multiplier NF (2 or more) |
| reqNo | input | NO_W | Requested output divider NO (1 or more) |
| lockIn | input | 1 | Lock status from the PLL |
| pllResetOut | output | 1 | Reset to the PLL, active high |
| pllModeOut | output | 2 | Mode field: 0 slow, 1 normal, 2 deep-slow |
| nrFieldOut | output | NR_W | Stored input divider, NR-1 |
| nfFieldOut | output | NF_W | Stored feedback multiplier, NF-1 |
| noFieldOut | output | NO_W | Stored output divider, NO-1 |
| bwAdjOut | output | BW_W | Loop bandwidth field, (NF>>1)-1 |
| busyOut | output | 1 | Sequence in progress |
| errOut | output | 1 | Last attempt ended without lock |
| rateHzOut | output | RATE_W | Current output frequency in Hz |

## Verification
The mode and reset change at the edge that takes the start, and the divider and bandwidth fields follow one edge later. Reset falls exactly RESET_US*CLK_MHZ edges after that, and lock decisions fall on every CLK_MHZ-th edge after the release. The rate output is combinational from these registers, so it is due in the same cycle. The bench keeps a behavioural model that counts the same edges from its own reading of these rules, and it compares every output at each falling clock edge. Every due cycle is therefore checked, and so is every cycle in which nothing is allowed to move.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  typedef enum logic [1:0] {
    MODE_SLOW   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_DEEP   = 2'd2
  } pll_mode_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic enterSlow;   // bypass + reset, capture request
    logic loadDiv;     // write divider and bandwidth fields
    logic releaseRst;  // drop PLL reset
    logic goNormal;    // hand output to the PLL
  } seq_strobe_t;

  localparam int REF_MHZ = 24;
  localparam int DEEP_HZ = 32768;

endpackage

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter int CLK_MHZ         = 250,
  parameter int RESET_US        = 10,
  parameter int LOCK_TIMEOUT_US = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        lockIn,
  output seq_strobe_t strobe,
  output logic        busyOut,
  output logic        errOut
);

  localparam int TICK_W = (CLK_MHZ > 2) ? $clog2(CLK_MHZ) : 1;
  localparam int US_MAX = (RESET_US > LOCK_TIMEOUT_US) ? RESET_US : LOCK_TIMEOUT_US;
  localparam int US_W   = $clog2(US_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_HOLD, ST_POLL} seq_state_e;

  seq_state_e        state, nextState;
  logic [TICK_W-1:0] tickCnt;
  logic [US_W-1:0]   usCnt;
  logic              usTick;
  logic              timeoutHit;
  logic              errQ;

  assign usTick = (tickCnt == TICK_W'(CLK_MHZ - 1));

  always_comb begin
    strobe     = '0;
    timeoutHit = 1'b0;
    nextState  = state;
    case (state)
      ST_IDLE: if (startPulse) begin
        strobe.enterSlow = 1'b1;
        nextState        = ST_LOAD;
      end
      ST_LOAD: begin
        strobe.loadDiv = 1'b1;
        nextState      = ST_HOLD;
      end
      ST_HOLD: if (usTick && usCnt == US_W'(RESET_US - 1)) begin
        strobe.releaseRst = 1'b1;
        nextState         = ST_POLL;
      end
      ST_POLL: if (usTick) begin
        if (lockIn) begin
          strobe.goNormal = 1'b1;
          nextState       = ST_IDLE;
        end else if (usCnt == US_W'(LOCK_TIMEOUT_US - 1)) begin
          timeoutHit = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      usCnt   <= '0;
      errQ    <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE || strobe.loadDiv || strobe.releaseRst)
        tickCnt <= '0;
      else if (usTick)
        tickCnt <= '0;
      else
        tickCnt <= tickCnt + 1'b1;
      if (strobe.loadDiv || strobe.releaseRst)
        usCnt <= '0;
      else if (usTick && (state == ST_HOLD || state == ST_POLL))
        usCnt <= usCnt + 1'b1;
      if (strobe.enterSlow)
        errQ <= 1'b0;
      else if (timeoutHit)
        errQ <= 1'b1;
    end
  end

  assign busyOut = (state != ST_IDLE);
  assign errOut  = errQ;

  // R7: a load step only ever follows idle, so starts while busy never restart
  a_r7_load_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |-> ($past(state) == ST_IDLE));

  // R8: an error flag is only present while the sequencer rests
  a_r8_err_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (state == ST_IDLE));

endmodule

// File: rtl/pllseq_dp.sv
module pllseq_dp
  import pllseq_pkg::*;
#(
  parameter int NR_W   = 6,
  parameter int NF_W   = 13,
  parameter int NO_W   = 4,
  parameter int BW_W   = 12,
  parameter int RATE_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [NR_W-1:0]   reqNr,
  input  logic [NF_W-1:0]   reqNf,
  input  logic [NO_W-1:0]   reqNo,
  output logic              pllResetOut,
  output logic [1:0]        pllModeOut,
  output logic [NR_W-1:0]   nrFieldOut,
  output logic [NF_W-1:0]   nfFieldOut,
  output logic [NO_W-1:0]   noFieldOut,
  output logic [BW_W-1:0]   bwAdjOut,
  output logic [RATE_W-1:0] rateHzOut
);

  pll_mode_e       modeQ;
  logic            pllRstQ;
  logic [NR_W-1:0] shNr, nrQ;
  logic [NF_W-1:0] shNf, nfQ;
  logic [NO_W-1:0] shNo, noQ;
  logic [BW_W-1:0] bwQ;
  logic [NF_W-1:0] halfNf;

  assign halfNf = shNf >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_DEEP;
      pllRstQ <= 1'b0;
      shNr    <= '0;
      shNf    <= '0;
      shNo    <= '0;
      nrQ     <= '0;
      nfQ     <= '0;
      noQ     <= '0;
      bwQ     <= '0;
    end else begin
      if (strobe.enterSlow) begin
        modeQ   <= MODE_SLOW;
        pllRstQ <= 1'b1;
        shNr    <= reqNr;
        shNf    <= reqNf;
        shNo    <= reqNo;
      end
      if (strobe.loadDiv) begin
        nrQ <= shNr - 1'b1;
        nfQ <= shNf - 1'b1;
        noQ <= shNo - 1'b1;
        bwQ <= BW_W'(halfNf) - 1'b1;
      end
      if (strobe.releaseRst) pllRstQ <= 1'b0;
      if (strobe.goNormal)   modeQ   <= MODE_NORMAL;
    end
  end

  // rate readback, combinational from the stored fields
  logic [RATE_W-1:0] numMhz, denom, quotMhz;

  always_comb begin
    numMhz  = RATE_W'(REF_MHZ) * (RATE_W'(nfQ) + 1'b1);
    denom   = (RATE_W'(nrQ) + 1'b1) * (RATE_W'(noQ) + 1'b1);
    quotMhz = numMhz / denom;
    case (modeQ)
      MODE_SLOW:   rateHzOut = RATE_W'(REF_MHZ * 1000000);
      MODE_NORMAL: rateHzOut = quotMhz * RATE_W'(1000000);
      default:     rateHzOut = RATE_W'(DEEP_HZ);
    endcase
  end

  assign pllResetOut = pllRstQ;
  assign pllModeOut  = modeQ;
  assign nrFieldOut  = nrQ;
  assign nfFieldOut  = nfQ;
  assign noFieldOut  = noQ;
  assign bwAdjOut    = bwQ;

  // R2: divider fields move only while bypassed and held in reset
  a_r2_fields_move_in_slow: assert property (@(posedge clk) disable iff (!rstN)
    (nrQ != $past(nrQ) || nfQ != $past(nfQ) || noQ != $past(noQ))
      |-> (modeQ == MODE_SLOW && pllRstQ));

endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
  import pllseq_pkg::*;
#(
  parameter int CLK_MHZ         = 250,
  parameter int RESET_US        = 10,
  parameter int LOCK_TIMEOUT_US = 1000,
  parameter int NR_W            = 6,
  parameter int NF_W            = 13,
  parameter int NO_W            = 4,
  parameter int BW_W            = 12,
  parameter int RATE_W          = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [NR_W-1:0]   reqNr,
  input  logic [NF_W-1:0]   reqNf,
  input  logic [NO_W-1:0]   reqNo,
  input  logic              lockIn,
  output logic              pllResetOut,
  output logic [1:0]        pllModeOut,
  output logic [NR_W-1:0]   nrFieldOut,
  output logic [NF_W-1:0]   nfFieldOut,
  output logic [NO_W-1:0]   noFieldOut,
  output logic [BW_W-1:0]   bwAdjOut,
  output logic              busyOut,
  output logic              errOut,
  output logic [RATE_W-1:0] rateHzOut
);

  seq_strobe_t strobe;

  pllseq_ctrl #(
    .CLK_MHZ(CLK_MHZ), .RESET_US(RESET_US), .LOCK_TIMEOUT_US(LOCK_TIMEOUT_US)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lockIn(lockIn),
    .strobe(strobe), .busyOut(busyOut), .errOut(errOut)
  );

  pllseq_dp #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W), .RATE_W(RATE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqNr(reqNr), .reqNf(reqNf), .reqNo(reqNo),
    .pllResetOut(pllResetOut), .pllModeOut(pllModeOut),
    .nrFieldOut(nrFieldOut), .nfFieldOut(nfFieldOut), .noFieldOut(noFieldOut),
    .bwAdjOut(bwAdjOut), .rateHzOut(rateHzOut)
  );

  logic modeIsNormal;
  assign modeIsNormal = (pllModeOut == MODE_NORMAL);

  // R5: normal mode is entered only after a lock seen out of reset
  a_r5_normal_after_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeIsNormal) |-> ($past(lockIn) && !pllResetOut));

  // R4: reset is released while the output is still bypassed
  a_r4_release_in_slow: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllResetOut) |-> (pllModeOut == MODE_SLOW));

  // R6: busy ends only with normal mode or with an error
  a_r6_busy_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> (modeIsNormal || errOut));

endmodule

// File: tb/pllseq_top_tb_top.sv
module pllseq_top_tb_top;

  localparam int CLK_MHZ = 250;
  localparam int RST_US  = 10;
  localparam int TO_US   = 20;
  localparam int NR_W = 6, NF_W = 13, NO_W = 4, BW_W = 12, RATE_W = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [NR_W-1:0] reqNr = '0;
  logic [NF_W-1:0] reqNf = '0;
  logic [NO_W-1:0] reqNo = '0;
  logic lockIn = 1'b0;
  logic pllResetOut, busyOut, errOut;
  logic [1:0] pllModeOut;
  logic [NR_W-1:0] nrFieldOut;
  logic [NF_W-1:0] nfFieldOut;
  logic [NO_W-1:0] noFieldOut;
  logic [BW_W-1:0] bwAdjOut;
  logic [RATE_W-1:0] rateHzOut;

  always #2 clk = ~clk;

  pllseq_top #(
    .CLK_MHZ(CLK_MHZ), .RESET_US(RST_US), .LOCK_TIMEOUT_US(TO_US),
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W), .RATE_W(RATE_W)
  ) dut_i (.*);

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mPhase = 0;        // 0 idle, 1 load, 2 hold, 3 poll
  int mCyc = 0, mFails = 0;
  int mMode = 2, mRst = 0, mErr = 0;
  int mNr = 0, mNf = 0, mNo = 0, mBw = 0;
  int shNr = 0, shNf = 0, shNo = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mMode = 2; mRst = 0; mErr = 0;
      mNr = 0; mNf = 0; mNo = 0; mBw = 0;
    end else begin
      case (mPhase)
        0: if (startPulse) begin
          mMode = 0; mRst = 1; mErr = 0;
          shNr = int'(reqNr); shNf = int'(reqNf); shNo = int'(reqNo);
          mPhase = 1;
        end
        1: begin
          mNr = shNr - 1; mNf = shNf - 1; mNo = shNo - 1;
          mBw = (shNf / 2) - 1;
          mPhase = 2; mCyc = 0;
        end
        2: begin
          mCyc++;
          if (mCyc == RST_US * CLK_MHZ) begin
            mRst = 0; mPhase = 3; mCyc = 0; mFails = 0;
          end
        end
        default: begin
          mCyc++;
          if (mCyc % CLK_MHZ == 0) begin
            if (lockIn) begin
              mMode = 1; mPhase = 0;
            end else begin
              mFails++;
              if (mFails == TO_US) begin
                mErr = 1; mPhase = 0;
              end
            end
          end
        end
      endcase
    end
  end

  function automatic longint expRate();
    if (mMode == 0) return 64'd24000000;
    if (mMode == 1)
      return (longint'(24 * (mNf + 1)) / longint'((mNr + 1) * (mNo + 1))) * 64'd1000000;
    return 64'd32768;
  endfunction

  // PLL model and per-cycle comparison, both away from the active edge
  int lockDelay = 10;
  bit noLock = 1'b0;
  int lockCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      chk("R2/R5 mode", longint'(pllModeOut), longint'(mMode));
      chk("R4 pll reset", longint'(pllResetOut), longint'(mRst));
      chk("R3 nr field", longint'(nrFieldOut), longint'(mNr));
      chk("R3 nf field", longint'(nfFieldOut), longint'(mNf));
      chk("R3 no field", longint'(noFieldOut), longint'(mNo));
      chk("R3 bw field", longint'(bwAdjOut), longint'(mBw));
      chk("R6 busy", longint'(busyOut), longint'(mPhase != 0));
      chk("R8 error", longint'(errOut), longint'(mErr));
      chk("R9 rate", longint'(rateHzOut), expRate());
    end
    if (pllResetOut) lockCnt = 0;
    else if (lockCnt < 1000000) lockCnt++;
    lockIn = !noLock && !pllResetOut && (lockCnt >= lockDelay);
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      miscompares++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic startReq(int nr, int nf, int no);
    @(negedge clk);
    reqNr = NR_W'(nr); reqNf = NF_W'(nf); reqNo = NO_W'(no);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitIdle();
    while (busyOut) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset mode deep-slow", longint'(pllModeOut), 2);
    chk("R1 reset rate", longint'(rateHzOut), 32768);
    chk("R1 reset busy", longint'(busyOut), 0);

    // 816 MHz, lock arrives between polls
    lockDelay = 300;
    startReq(1, 68, 2);
    chk("R2 slow after start", longint'(pllModeOut), 0);
    chk("R9 slow rate", longint'(rateHzOut), 24000000);
    waitIdle();
    chk("R5 normal entered", longint'(pllModeOut), 1);
    chk("R9 normal rate 816", longint'(rateHzOut), 64'd816000000);

    // 800 MHz, early lock; a second start during hold is ignored (R7)
    lockDelay = 3;
    startReq(12, 800, 2);
    repeat (100) @(negedge clk);
    startReq(3, 99, 5);
    waitIdle();
    chk("R7 nr kept", longint'(nrFieldOut), 11);
    chk("R7 nf kept", longint'(nfFieldOut), 799);
    chk("R9 normal rate 800", longint'(rateHzOut), 64'd800000000);

    // no lock: timeout path (R8)
    noLock = 1'b1;
    startReq(1, 50, 6);
    waitIdle();
    chk("R8 error set", longint'(errOut), 1);
    chk("R8 mode stays slow", longint'(pllModeOut), 0);
    chk("R9 rate after timeout", longint'(rateHzOut), 24000000);
    noLock = 1'b0;

    // odd NF, error cleared by the next start
    lockDelay = 1000;
    startReq(3, 201, 2);
    chk("R8 error cleared", longint'(errOut), 0);
    waitIdle();
    chk("R3 bw odd nf", longint'(bwAdjOut), 99);
    chk("R9 rate 804", longint'(rateHzOut), 64'd804000000);

    // truncating rate
    lockDelay = 600;
    startReq(7, 100, 1);
    waitIdle();
    chk("R9 truncated rate", longint'(rateHzOut), 64'd342000000);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule